// File: doc/BRIEF.md
# Codec-Side Serial Audio Link Responder

This block is the digital front end of an audio codec on a five-wire serial audio link. Frames are 256 bit clocks long. A rising edge on the frame sync input marks the first bit of a frame. Each frame holds a 16-bit tag slot followed by twelve 20-bit slots, and every slot is sent most significant bit first. The block deserializes the controller's output stream and decodes register reads and writes into a small control register file. It accepts playback samples from the controller and presents them on a parallel DAC port. Each frame it assembles the return stream, which carries the tag, the register read-back, the slot request bits and two capture channels taken from a parallel ADC port.

A variable-rate option lets the playback and capture rates fall below the 48 kHz frame rate. A phase accumulator per direction then decides which frames carry a capture sample. It also decides which frames request playback data, and playback data that arrives without a prior request is dropped. The identification registers are fixed, with one field reflecting the codec identity pins. Writing the reset register, or pulling the active-low cold reset, returns every register to its default.

Top module: `codec_link_responder`

## Requirements
- R1: A frame begins in the cycle where `sync` is first sampled high after being low; that cycle is position 0. The return bit for position p is driven on `sdata_in` in the cycle after position p. Before the first frame after reset, `sdata_in` is 0.
- R2: Return tag slot (bit 15 first): bit 15 (codec ready) is always 1. Bits 14 and 13 are 1 exactly when the frame carries a read response. Bits 12 and 11 are 1 exactly when the frame carries capture samples. Bits 10:0 are 0.
- R3: A write is taken when the incoming tag has bits 15, 14 and 13 set, tag bits 1:0 equal `codec_id`, and slot 1 bit 19 is 0. The register index is slot 1 bits 18:12 and the data is slot 2 bits 19:4. A command whose tag identity differs is ignored.
- R4: A read (tag bits 15 and 14 set, identity match, slot 1 bit 19 = 1) is answered in the next frame only. The response echoes the index in return slot 1 bits 18:12, puts the data in return slot 2 bits 19:4, and drives slot 2 bits 3:0 as 0.
- R5: Index 00h reads 0D40h. A write of any value to 00h restores all defaults: 02h = 8000h, 18h = 8808h, 26h control bits 0, 2Ah = 0, and 2Ch = 32h = BB80h.
- R6: Index 28h reads {codec_id, 13'b0, 1'b1} and ignores writes.
- R7: Index 26h stores bit 15 and bits 13:8. It reads bit 14 and bits 7:4 as 0, and bits 3:0 as the inverse of stored bits 11:8.
- R8: Writes to indices other than 00h, 02h, 18h, 26h, 2Ah, 2Ch and 32h are ignored, and reads of those indices return 0.
- R9: Return slot 1 bits 11 and 10 are active-low requests for playback slots 3 and 4. Bits 19 and 9:0 are always 0, and bits 18:12 are 0 without a response. Slots 5 to 12 are all 0.
- R10: A capture frame carries `{adc_left, 2'b00}` in slot 3 and `{adc_right, 2'b00}` in slot 4, sampled at the frame's position 0. Other frames carry zeros there.
- R11: Each direction keeps an accumulator, starting at 0. Each frame it adds the effective rate; when the sum reaches 48000 the frame fires and 48000 is subtracted. The effective rate is 48000 when 2Ah bit 0 is 0; otherwise it is 2Ch (playback) or 32h (capture), clamped to 48000.
- R12: Playback slots 3 and 4 (data in bits 19:2) are taken only when the previous frame requested them and both incoming tag bits 12 and 11 are set. They then appear on `dac_left`/`dac_right` with a one-cycle `dac_stb`; otherwise the data is discarded.
- R13: Cold reset returns all registers, accumulators and pending responses to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low cold reset |
| sync | input | 1 | Frame sync from the controller |
| sdata_out | input | 1 | Serial stream from the controller |
| sdata_in | output | 1 | Serial return stream to the controller |
| codec_id | input | 2 | Codec identity pins |
| adc_left | input | 18 | Left capture sample |
| adc_right | input | 18 | Right capture sample |
| dac_left | output | 18 | Left playback sample |
| dac_right | output | 18 | Right playback sample |
| dac_stb | output | 1 | Playback sample pair valid |

## Verification
Faults in the position counter or the slot latch points corrupt the very next frame. A lost or shifted tag bit, a misplaced index echo, or nonzero stuffing then shows in the returned stream within 256 cycles. A corrupted register or a bad reset default stays hidden until that index is read, and the read answer arrives one frame after the request. A drifted rate accumulator shows up over several frames, as a request or capture pattern that differs from the frame-by-frame one-in-N sequence.

// File: rtl/clr_pkg.sv
package clr_pkg;
  localparam int FRAME_BITS = 256;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = 7;
  localparam int RATE_W     = 17;
  localparam int LINK_HZ    = 48000;

  localparam logic [DATA_W-1:0] ID_WORD   = 16'h0D40;
  localparam logic [DATA_W-1:0] MVOL_DEF  = 16'h8000;
  localparam logic [DATA_W-1:0] PCMV_DEF  = 16'h8808;
  localparam logic [DATA_W-1:0] RATE_DEF  = 16'hBB80;

  localparam logic [IDX_W-1:0] IX_RESET = 7'h00;
  localparam logic [IDX_W-1:0] IX_MVOL  = 7'h02;
  localparam logic [IDX_W-1:0] IX_PCMV  = 7'h18;
  localparam logic [IDX_W-1:0] IX_PWR   = 7'h26;
  localparam logic [IDX_W-1:0] IX_EXTID = 7'h28;
  localparam logic [IDX_W-1:0] IX_EXTCT = 7'h2A;
  localparam logic [IDX_W-1:0] IX_DRATE = 7'h2C;
  localparam logic [IDX_W-1:0] IX_ARATE = 7'h32;

  // Effective converter rate: full link rate unless variable rate is enabled.
  function automatic logic [RATE_W-1:0] rate_eff(input logic vra, input logic [DATA_W-1:0] rate);
    logic [RATE_W-1:0] wide;
    wide = {1'b0, rate};
    if (!vra || wide > RATE_W'(LINK_HZ)) return RATE_W'(LINK_HZ);
    return wide;
  endfunction

  function automatic logic [DATA_W-1:0] pwr_readback(input logic eapd, input logic [5:0] pr);
    return {eapd, 1'b0, pr, 4'h0, ~pr[3:0]};
  endfunction

  function automatic logic [DATA_W-1:0] ext_id_word(input logic [1:0] id);
    return {id, 13'h0, 1'b1};
  endfunction

  // Return frame, index FRAME_BITS-1 is sent first.
  function automatic logic [FRAME_BITS-1:0] build_return(
    input logic              resp_v,
    input logic [IDX_W-1:0]  resp_idx,
    input logic [DATA_W-1:0] resp_dat,
    input logic              play_req,
    input logic              cap_v,
    input logic [SLOT_W-1:0] cap_l,
    input logic [SLOT_W-1:0] cap_r);
    logic [TAG_W-1:0]  tag;
    logic [SLOT_W-1:0] s1, s2, s3, s4;
    tag = {1'b1, resp_v, resp_v, cap_v, cap_v, 11'h0};
    s1  = {1'b0, (resp_v ? resp_idx : '0), ~play_req, ~play_req, 10'h0};
    s2  = resp_v ? {resp_dat, 4'h0} : '0;
    s3  = cap_v ? cap_l : '0;
    s4  = cap_v ? cap_r : '0;
    return {tag, s1, s2, s3, s4, {(FRAME_BITS - TAG_W - 4*SLOT_W){1'b0}}};
  endfunction
endpackage

// File: rtl/clr_frame_timer.sv
module clr_frame_timer #(
  parameter int FRAME_BITS = 256,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  output logic [PW-1:0] pos,
  output logic          frame_start,
  output logic          active
);
  logic          sync_q;
  logic          active_q;
  logic [PW-1:0] cnt_q;

  assign frame_start = sync & ~sync_q;
  assign pos         = frame_start ? '0 : cnt_q;
  assign active      = active_q | frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync_q <= sync;
      if (frame_start) active_q <= 1'b1;
      if (active) cnt_q <= pos + 1'b1;
    end
  end

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pos == PW'(1))); // R1
endmodule

// File: rtl/clr_rate_gate.sv
module clr_rate_gate #(
  parameter int RATE_W  = 17,
  parameter int LINK_HZ = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, rate};
  assign fire = sum >= (RATE_W+1)'(LINK_HZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (step) acc_q <= fire ? RATE_W'(sum - (RATE_W+1)'(LINK_HZ)) : RATE_W'(sum);
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < RATE_W'(LINK_HZ)); // R11
  AST_FULL_RATE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_W'(LINK_HZ)) |-> fire); // R11
endmodule

// File: rtl/clr_regfile.sv
module clr_regfile
  import clr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        codec_id,
  output logic              vra,
  output logic [DATA_W-1:0] play_rate,
  output logic [DATA_W-1:0] cap_rate
);
  logic [DATA_W-1:0] mvol_q, pcmv_q, prate_q, crate_q;
  logic              eapd_q, vra_q;
  logic [5:0]        pr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mvol_q  <= MVOL_DEF;
      pcmv_q  <= PCMV_DEF;
      prate_q <= RATE_DEF;
      crate_q <= RATE_DEF;
      eapd_q  <= 1'b0;
      pr_q    <= '0;
      vra_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_idx)
        IX_RESET: begin
          mvol_q  <= MVOL_DEF;
          pcmv_q  <= PCMV_DEF;
          prate_q <= RATE_DEF;
          crate_q <= RATE_DEF;
          eapd_q  <= 1'b0;
          pr_q    <= '0;
          vra_q   <= 1'b0;
        end
        IX_MVOL:  mvol_q  <= wr_data;
        IX_PCMV:  pcmv_q  <= wr_data;
        IX_PWR: begin
          eapd_q <= wr_data[15];
          pr_q   <= wr_data[13:8];
        end
        IX_EXTCT: vra_q   <= wr_data[0];
        IX_DRATE: prate_q <= wr_data;
        IX_ARATE: crate_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      IX_RESET: rd_data = ID_WORD;
      IX_MVOL:  rd_data = mvol_q;
      IX_PCMV:  rd_data = pcmv_q;
      IX_PWR:   rd_data = pwr_readback(eapd_q, pr_q);
      IX_EXTID: rd_data = ext_id_word(codec_id);
      IX_EXTCT: rd_data = {15'h0, vra_q};
      IX_DRATE: rd_data = prate_q;
      IX_ARATE: rd_data = crate_q;
      default:  rd_data = '0;
    endcase
  end

  assign vra       = vra_q;
  assign play_rate = prate_q;
  assign cap_rate  = crate_q;

  AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_RESET) |=> (mvol_q == MVOL_DEF && !vra_q && prate_q == RATE_DEF)); // R5
  AST_PWR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IX_PWR) |-> (rd_data[14] == 1'b0 && rd_data[7:4] == 4'h0)); // R7
  AST_IDREG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_EXTID) |=> ($stable(mvol_q) && $stable(pr_q) && $stable(vra_q))); // R6
endmodule

// File: rtl/codec_link_responder.sv
module codec_link_responder
  import clr_pkg::*;
#(
  parameter int SAMPLE_W = 18
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                sync,
  input  logic                sdata_out,
  output logic                sdata_in,
  input  logic [1:0]          codec_id,
  input  logic [SAMPLE_W-1:0] adc_left,
  input  logic [SAMPLE_W-1:0] adc_right,
  output logic [SAMPLE_W-1:0] dac_left,
  output logic [SAMPLE_W-1:0] dac_right,
  output logic                dac_stb
);
  localparam int PW     = $clog2(FRAME_BITS);
  localparam int PAD    = SLOT_W - SAMPLE_W;
  localparam int TAG_END = TAG_W - 1;
  localparam int S1_END  = TAG_END + SLOT_W;
  localparam int S2_END  = S1_END + SLOT_W;
  localparam int S3_END  = S2_END + SLOT_W;
  localparam int S4_END  = S3_END + SLOT_W;

  logic [PW-1:0] pos;
  logic          frame_start, act;

  clr_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(bit_clk), .rst_n(rst_n), .sync(sync),
    .pos(pos), .frame_start(frame_start), .active(act)
  );

  // Receive side: slot word completes at each slot's last position.
  logic [SLOT_W-2:0] rx_sr;
  logic [SLOT_W-1:0] slot_word;
  assign slot_word = {rx_sr, sdata_out};

  logic             t_frame_v, t_s1_v, t_s2_v, t_l_v, t_r_v;
  logic [1:0]       t_id;
  logic             s1_rd;
  logic [IDX_W-1:0] s1_idx;

  // Register command decode at end of slot 2.
  logic              cmd_ok, wr_en, rd_cmd;
  logic [DATA_W-1:0] rd_data;
  assign cmd_ok = act && (pos == PW'(S2_END)) && t_frame_v && t_s1_v && (t_id == codec_id);
  assign wr_en  = cmd_ok && !s1_rd && t_s2_v;
  assign rd_cmd = cmd_ok && s1_rd;

  logic              vra;
  logic [DATA_W-1:0] play_rate, cap_rate;

  clr_regfile u_regs (
    .clk(bit_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(s1_idx), .wr_data(slot_word[SLOT_W-1 -: DATA_W]),
    .rd_idx(s1_idx), .rd_data(rd_data), .codec_id(codec_id),
    .vra(vra), .play_rate(play_rate), .cap_rate(cap_rate)
  );

  // Rate gates, one per direction.
  logic [1:0] gate_fire;
  logic [RATE_W-1:0] gate_rate [2];
  assign gate_rate[0] = rate_eff(vra, play_rate);
  assign gate_rate[1] = rate_eff(vra, cap_rate);

  for (genvar g = 0; g < 2; g++) begin : g_gate
    clr_rate_gate #(.RATE_W(RATE_W), .LINK_HZ(LINK_HZ)) u_gate (
      .clk(bit_clk), .rst_n(rst_n), .step(frame_start),
      .rate(gate_rate[g]), .fire(gate_fire[g])
    );
  end

  // Return frame assembly.
  logic              resp_v;
  logic [IDX_W-1:0]  resp_idx;
  logic [DATA_W-1:0] resp_dat;
  logic [FRAME_BITS-1:0] frame_vec, tx_frame;
  logic              out_q;

  assign frame_vec = build_return(resp_v, resp_idx, resp_dat, gate_fire[0], gate_fire[1],
                                  {adc_left, {PAD{1'b0}}}, {adc_right, {PAD{1'b0}}});

  // Playback acceptance.
  logic                play_req_q, play_open;
  logic [SAMPLE_W-1:0] dac_l_q;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr      <= '0;
      t_frame_v  <= 1'b0;
      t_s1_v     <= 1'b0;
      t_s2_v     <= 1'b0;
      t_l_v      <= 1'b0;
      t_r_v      <= 1'b0;
      t_id       <= '0;
      s1_rd      <= 1'b0;
      s1_idx     <= '0;
      resp_v     <= 1'b0;
      resp_idx   <= '0;
      resp_dat   <= '0;
      tx_frame   <= '0;
      out_q      <= 1'b0;
      play_req_q <= 1'b0;
      play_open  <= 1'b0;
      dac_l_q    <= '0;
      dac_left   <= '0;
      dac_right  <= '0;
      dac_stb    <= 1'b0;
    end else begin
      rx_sr   <= slot_word[SLOT_W-2:0];
      dac_stb <= 1'b0;
      if (act) begin
        if (pos == PW'(TAG_END)) begin
          t_frame_v <= slot_word[15];
          t_s1_v    <= slot_word[14];
          t_s2_v    <= slot_word[13];
          t_l_v     <= slot_word[12];
          t_r_v     <= slot_word[11];
          t_id      <= slot_word[1:0];
        end
        if (pos == PW'(S1_END)) begin
          s1_rd  <= slot_word[SLOT_W-1];
          s1_idx <= slot_word[SLOT_W-2 -: IDX_W];
        end
        if (rd_cmd) begin
          resp_v   <= 1'b1;
          resp_idx <= s1_idx;
          resp_dat <= rd_data;
        end else if (frame_start) begin
          resp_v <= 1'b0;
        end
        if (frame_start) begin
          tx_frame   <= frame_vec;
          play_open  <= play_req_q;
          play_req_q <= gate_fire[0];
        end
        if (pos == PW'(S3_END) && play_open && t_l_v)
          dac_l_q <= slot_word[SLOT_W-1 -: SAMPLE_W];
        if (pos == PW'(S4_END) && play_open && t_l_v && t_r_v) begin
          dac_left  <= dac_l_q;
          dac_right <= slot_word[SLOT_W-1 -: SAMPLE_W];
          dac_stb   <= 1'b1;
        end
        out_q <= frame_start ? frame_vec[FRAME_BITS-1] : tx_frame[~pos];
      end else begin
        out_q <= 1'b0;
      end
    end
  end

  assign sdata_in = out_q;

  AST_STB_NEEDS_GRANT: assert property (@(posedge bit_clk) disable iff (!rst_n)
    dac_stb |-> play_open); // R12
  AST_STB_SINGLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    dac_stb |=> !dac_stb); // R12
  AST_RESP_ONE_FRAME: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (frame_start && resp_v) |=> !resp_v); // R4
  AST_IDLE_LINK_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!act && !$past(act)) |-> !sdata_in); // R1
endmodule

// File: tb/codec_link_responder_bench.sv
module codec_link_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n, sync, sdata_out;
  logic        sdata_in, dac_stb;
  logic [1:0]  codec_id;
  logic [17:0] adc_left, adc_right, dac_left, dac_right;

  always #2 clk = ~clk;

  codec_link_responder u_codec_link_responder (
    .bit_clk(clk), .rst_n(rst_n), .sync(sync), .sdata_out(sdata_out),
    .sdata_in(sdata_in), .codec_id(codec_id),
    .adc_left(adc_left), .adc_right(adc_right),
    .dac_left(dac_left), .dac_right(dac_right), .dac_stb(dac_stb)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // Bench mirror of rate state, written from the requirement text.
  bit        m_vra;
  int        m_prate, m_crate, m_pacc, m_cacc;
  bit        m_prev_req;
  int        fires_p, fires_c;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eff(input bit vra, input int rate);
    if (!vra) return 48000;
    return (rate > 48000) ? 48000 : rate;
  endfunction

  function automatic logic [255:0] mkf(input logic [15:0] tag, input logic [19:0] s1,
                                        input logic [19:0] s2, input logic [19:0] s3,
                                        input logic [19:0] s4);
    return {tag, s1, s2, s3, s4, 160'h0};
  endfunction

  task automatic model_reset();
    m_vra = 0; m_prate = 48000; m_crate = 48000;
    m_pacc = 0; m_cacc = 0; m_prev_req = 0;
  endtask

  task automatic send_frame(input logic [255:0] f, output logic [255:0] r);
    bit pf, cf, stb_seen, exp_stb;
    logic [17:0] dl, dr;
    logic [15:0] tg;
    logic [19:0] s1, s2;
    int sp, sc;
    sp = m_pacc + eff(m_vra, m_prate);
    pf = sp >= 48000;
    m_pacc = pf ? sp - 48000 : sp;
    sc = m_cacc + eff(m_vra, m_crate);
    cf = sc >= 48000;
    m_cacc = cf ? sc - 48000 : sc;
    fires_p += pf; fires_c += cf;
    stb_seen = 0; dl = '0; dr = '0;
    for (int p = 0; p < 256; p++) begin
      sync = (p < 16);
      sdata_out = f[255-p];
      @(negedge clk);
      r[255-p] = sdata_in;
      if (dac_stb) begin stb_seen = 1; dl = dac_left; dr = dac_right; end
    end
    tg = f[255:240]; s1 = f[239:220]; s2 = f[219:200];
    // R2 tag slot
    chk(r[255] == 1'b1 && r[250:240] == 11'h0 && r[254] == r[253], "R2 tag ready/zero bits",
        {16'h0, r[255:240]}, 32'h8000);
    chk(r[252] == cf && r[251] == cf, "R2/R10 capture tag bits", {30'h0, r[252:251]}, {30'h0, cf, cf});
    // R9 request bits and stuffing; R11 via the bench accumulator
    chk(r[231] == ~pf && r[230] == ~pf, "R9 R11 playback request bits", {30'h0, r[231:230]}, {30'h0, ~pf, ~pf});
    chk(r[239] == 1'b0 && r[229:220] == 10'h0 && r[159:0] == 160'h0 &&
        (r[254] || (r[238:232] == 7'h0 && r[219:200] == 20'h0)),
        "R9 zero stuffing", {22'h0, r[229:220]}, 32'h0);
    // R10 capture slots
    chk(r[199:160] == (cf ? {adc_left, 2'b00, adc_right, 2'b00} : 40'h0), "R10 capture slots",
        r[199:168], cf ? {adc_left, 2'b00, adc_right[17:6]} : 32'h0);
    // R12 playback acceptance
    exp_stb = m_prev_req && tg[12] && tg[11];
    chk(stb_seen == exp_stb, "R12 playback strobe", {31'h0, stb_seen}, {31'h0, exp_stb});
    if (exp_stb && stb_seen)
      chk(dl == f[199:182] && dr == f[179:162], "R12 playback data", {14'h0, dl}, {14'h0, f[199:182]});
    m_prev_req = pf;
    // mirror register writes that affect rates
    if (tg[15] && tg[14] && tg[13] && !s1[19] && tg[1:0] == codec_id) begin
      case (s1[18:12])
        7'h00: begin m_vra = 0; m_prate = 48000; m_crate = 48000; end
        7'h2A: m_vra = s2[4];
        7'h2C: m_prate = int'(s2[19:4]);
        7'h32: m_crate = int'(s2[19:4]);
        default: ;
      endcase
    end
  endtask

  task automatic cmd_wr(input logic [6:0] idx, input logic [15:0] d, input logic [1:0] id);
    logic [255:0] r;
    send_frame(mkf({3'b111, 11'h0, id}, {1'b0, idx, 12'h0}, {d, 4'h0}, 20'h0, 20'h0), r);
  endtask

  task automatic cmd_rd(input logic [6:0] idx, input logic [1:0] id, output logic [15:0] d, output bit got);
    logic [255:0] r1, r2;
    send_frame(mkf({2'b11, 12'h0, id}, {1'b1, idx, 12'h0}, 20'h0, 20'h0, 20'h0), r1);
    chk(r1[254] == 1'b0, "R4 no response in request frame", {31'h0, r1[254]}, 32'h0);
    send_frame(mkf(16'h8000, 20'h0, 20'h0, 20'h0, 20'h0), r2);
    got = r2[254];
    d = r2[219:204];
    if (got) chk(r2[238:232] == idx && r2[203:200] == 4'h0, "R4 index echo",
                 {25'h0, r2[238:232]}, {25'h0, idx});
  endtask

  task automatic expect_rd(input logic [6:0] idx, input logic [15:0] exp, input string req);
    logic [15:0] d; bit got;
    cmd_rd(idx, codec_id, d, got);
    chk(got && d == exp, req, {15'h0, got, d}, {16'h1, exp});
  endtask

  task automatic cold_reset();
    @(negedge clk);
    rst_n = 0; sync = 0; sdata_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    repeat (5) begin
      @(negedge clk);
      chk(sdata_in == 1'b0 && dac_stb == 1'b0, "R1 R13 idle before first frame",
          {30'h0, sdata_in, dac_stb}, 32'h0);
    end
  endtask

  task automatic t_id_regs();
    expect_rd(7'h00, 16'h0D40, "R5 reset register read");
    expect_rd(7'h28, 16'h0001, "R6 extended id, id=0");
    cmd_wr(7'h28, 16'hFFFF, codec_id);
    expect_rd(7'h28, 16'h0001, "R6 write to read-only ignored");
  endtask

  task automatic t_write_readback();
    cmd_wr(7'h02, 16'h1234, codec_id);
    expect_rd(7'h02, 16'h1234, "R3 write/read master volume");
    cmd_wr(7'h18, 16'hA5C3, codec_id);
    expect_rd(7'h18, 16'hA5C3, "R3 write/read pcm volume");
    cmd_wr(7'h7C, 16'hBEEF, codec_id);
    expect_rd(7'h7C, 16'h0000, "R8 unimplemented reads zero");
    cmd_wr(7'h03, 16'hBEEF, codec_id);
    expect_rd(7'h02, 16'h1234, "R8 odd index write ignored");
  endtask

  task automatic t_wrong_id();
    logic [15:0] d; bit got;
    cmd_wr(7'h02, 16'h5555, 2'b01);
    expect_rd(7'h02, 16'h1234, "R3 write with other identity ignored");
    cmd_rd(7'h02, 2'b11, d, got);
    chk(!got, "R4 read with other identity unanswered", {31'h0, got}, 32'h0);
  endtask

  task automatic t_powerdown();
    expect_rd(7'h26, 16'h000F, "R7 powerdown default");
    cmd_wr(7'h26, 16'hFFFF, codec_id);
    expect_rd(7'h26, 16'hBF00, "R7 powerdown all set");
    cmd_wr(7'h26, 16'h8500, codec_id);
    expect_rd(7'h26, 16'h850A, "R7 powerdown partial");
  endtask

  task automatic t_soft_reset();
    cmd_wr(7'h2C, 16'h1F40, codec_id);
    cmd_wr(7'h00, 16'h0000, codec_id);
    expect_rd(7'h02, 16'h8000, "R5 register reset master volume");
    expect_rd(7'h18, 16'h8808, "R5 register reset pcm volume");
    expect_rd(7'h2C, 16'hBB80, "R5 register reset playback rate");
    expect_rd(7'h26, 16'h000F, "R5 register reset powerdown");
  endtask

  task automatic t_identity_pins();
    @(negedge clk);
    codec_id = 2'b10;
    expect_rd(7'h28, 16'h8001, "R6 extended id follows pins");
    codec_id = 2'b00;
  endtask

  task automatic t_capture_full_rate();
    logic [255:0] r;
    adc_left = 18'h2ABCD; adc_right = 18'h15432;
    send_frame(mkf(16'h8000, 20'h0, 20'h0, 20'h0, 20'h0), r);
    chk(r[199:180] == {18'h2ABCD, 2'b00}, "R10 left sample packing", {12'h0, r[199:180]}, {12'h0, 18'h2ABCD, 2'b00});
    adc_left = 18'h3FFFF; adc_right = 18'h00001;
    send_frame(mkf(16'h8000, 20'h0, 20'h0, 20'h0, 20'h0), r);
    chk(r[161:160] == 2'b00 && r[179:162] == 18'h00001, "R10 right sample packing",
        {14'h0, r[179:162]}, 32'h1);
  endtask

  task automatic t_playback_full_rate();
    logic [255:0] r;
    for (int k = 0; k < 3; k++)
      send_frame(mkf(16'h9800, 20'h0, 20'h0, {18'(k*5+1), 2'b00}, {18'(k*7+2), 2'b00}), r);
    // tags for only one channel: discarded
    send_frame(mkf(16'h9000, 20'h0, 20'h0, {18'h11111, 2'b00}, 20'h0), r);
  endtask

  task automatic t_variable_rate();
    logic [255:0] r;
    cmd_wr(7'h2A, 16'h0001, codec_id);
    cmd_wr(7'h2C, 16'd8000, codec_id);
    cmd_wr(7'h32, 16'd16000, codec_id);
    fires_p = 0; fires_c = 0;
    for (int k = 0; k < 12; k++)
      send_frame(mkf(16'h9800, 20'h0, 20'h0, {18'(k+100), 2'b00}, {18'(k+200), 2'b00}), r);
    chk(fires_p == 2, "R11 one request in six frames at 8000", fires_p, 2);
    chk(fires_c == 4, "R11 one capture in three frames at 16000", fires_c, 4);
    cmd_wr(7'h2C, 16'hFFFF, codec_id);
    fires_p = 0;
    for (int k = 0; k < 4; k++)
      send_frame(mkf(16'h9800, 20'h0, 20'h0, {18'(k+300), 2'b00}, {18'(k+400), 2'b00}), r);
    chk(fires_p == 4, "R11 rate above link rate clamps", fires_p, 4);
  endtask

  task automatic t_cold_reset();
    cmd_wr(7'h02, 16'h4321, codec_id);
    cold_reset();
    t_reset_state();
    expect_rd(7'h02, 16'h8000, "R13 cold reset master volume");
    expect_rd(7'h2A, 16'h0000, "R13 cold reset variable rate off");
  endtask

  initial begin
    rst_n = 0; sync = 0; sdata_out = 0; codec_id = 2'b00;
    adc_left = 18'h0; adc_right = 18'h0;
    model_reset();
    fires_p = 0; fires_c = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_id_regs();
    t_write_readback();
    t_wrong_id();
    t_powerdown();
    t_soft_reset();
    t_identity_pins();
    t_capture_full_rate();
    t_playback_full_rate();
    t_variable_rate();
    t_cold_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule